// File: doc/BRIEF.md
# Beam Position Counter for NTSC and PAL Timing

This block keeps track of where the video beam is. It advances one horizontal count on every color clock. At the end of each line it advances the vertical count, and at the end of each field it wraps the vertical count back to zero. A select input chooses between NTSC and PAL timing, and an interlace input makes consecutive fields alternate in length. The block exports the raw counts and an 8-bit compare value built from the vertical count. It also exports a flag for the type of the current line and a flag for the type of the current field.

The block produces two single-cycle pulses. The first, a frame-start pulse, marks the first color clock of a new field. The second, a blank-end pulse, marks the first color clock of a line chosen by a parameter. A display coprocessor uses this second pulse to restart its instruction list. All pins are plain control and status signals, so the block needs no flow control: every output is valid on every cycle.

Top module: `beam_pos_counter`

## Requirements
- R1: While reset is held, and immediately after it is applied, `hpos`, `vpos`, `long_line`, `long_field`, `vb_start` and `vb_end` are all 0.
- R2: In NTSC mode the line type alternates on every line, including across field boundaries, and the first line after reset is short. A short line has `long_line`=0 and counts 0..0xE2, which is 227 clocks. A long line has `long_line`=1 and counts 0..0xE3, which is 228 clocks.
- R3: In PAL mode every line counts 0..0xE2, which is 227 clocks, and `long_line` stays 0. `pal_sel` is sampled at each line end.
- R4: With interlace off, a field has NTSC_LINES lines (default 262) in NTSC mode and PAL_LINES lines (default 312) in PAL mode, and `long_field` is 0.
- R5: `long_field` changes only at a field wrap. At the wrap it becomes the inverse of its old value if `ilace_en` is 1, and 0 otherwise. A field with `long_field`=1 has one extra line: 263 lines in NTSC, 313 lines in PAL.
- R6: NTSC interlace from reset gives a repeating cycle of four fields: short field ending on a long line, long field ending on a short line, short field ending on a short line, then long field ending on a long line.
- R7: `vcmp` equals the low 8 bits of `vpos`, so line 256 shows as 0.
- R8: `vb_start` is 1 for exactly the first clock of line 0 after a field wrap. It is 0 in the first cycle after reset.
- R9: `vb_end` is 1 for exactly the first clock of line VBEND_LINE (default 20) in each field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Color clock, one count per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_sel | input | 1 | 1 selects PAL timing, 0 selects NTSC timing |
| ilace_en | input | 1 | 1 makes field lengths alternate |
| hpos | output | HW (8) | Horizontal count within the line |
| vpos | output | VW (9) | Line count within the field |
| vcmp | output | 8 | Low 8 bits of the line count, for comparison |
| long_line | output | 1 | Current line is a 228-clock line |
| long_field | output | 1 | Current field has the extra line |
| vb_start | output | 1 | Pulse on the first clock of a new field |
| vb_end | output | 1 | Pulse on the first clock of line VBEND_LINE |

## Verification
The bench tests the counters under five kinds of stimulus, and each one separates different faults:

- **NTSC progressive (full size):** exposes errors in line-length alternation and in the 262-line field length, and shows line 256 as compare value 0.
- **PAL progressive (full size):** exposes any line alternation that leaks into PAL, and checks the 312-line field length.
- **NTSC interlace over five fields (shortened instance):** distinguishes the correct four-field cycle from a field flag that never toggles or a line parity that restarts at each field.
- **PAL interlace, then interlace switched off:** shows that the field flag toggles and then clears at the next wrap.
- **Reset applied mid-field:** shows that reset returns every output to zero and suppresses a false frame-start pulse.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int H_SHORT_LAST_DEF = 226;  // 0xE2, last count of a short line
  localparam int NTSC_LINES_DEF   = 262;
  localparam int PAL_LINES_DEF    = 312;
  localparam int VBEND_LINE_DEF   = 20;
  localparam int CMP_W            = 8;

  typedef enum logic { STD_NTSC = 1'b0, STD_PAL = 1'b1 } video_std_e;
endpackage

// File: rtl/beam_hcnt.sv
module beam_hcnt #(
  parameter int H_SHORT_LAST = 226,
  parameter int HW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pal_sel,
  output logic [HW-1:0] hpos,
  output logic          long_line,
  output logic          line_end
);
  import beam_pkg::*;

  localparam logic [HW-1:0] LAST_S = HW'(H_SHORT_LAST);
  localparam logic [HW-1:0] LAST_L = HW'(H_SHORT_LAST + 1);

  video_std_e std;
  assign std      = video_std_e'(pal_sel);
  assign line_end = (hpos == (long_line ? LAST_L : LAST_S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos      <= '0;
      long_line <= 1'b0;
    end else if (line_end) begin
      hpos      <= '0;
      // PAL lines are uniform; NTSC lines alternate long and short
      long_line <= (std == STD_PAL) ? 1'b0 : ~long_line;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end
endmodule

// File: rtl/beam_vcnt.sv
module beam_vcnt #(
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int VBEND_LINE = 20,
  parameter int VW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          pal_sel,
  input  logic          ilace_en,
  output logic [VW-1:0] vpos,
  output logic          long_field,
  output logic          vb_start,
  output logic          vb_end
);
  localparam logic [VW-1:0] LAST_NTSC = VW'(NTSC_LINES - 1);
  localparam logic [VW-1:0] LAST_PAL  = VW'(PAL_LINES - 1);
  localparam logic [VW-1:0] PRE_VBEND = VW'(VBEND_LINE - 1);

  logic [VW-1:0] field_last;
  logic          wrap;

  // a long field carries one extra line
  assign field_last = (pal_sel ? LAST_PAL : LAST_NTSC) + VW'(long_field);
  assign wrap       = line_end && (vpos == field_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpos       <= '0;
      long_field <= 1'b0;
      vb_start   <= 1'b0;
      vb_end     <= 1'b0;
    end else begin
      vb_start <= wrap;
      vb_end   <= line_end && !wrap && (vpos == PRE_VBEND);
      if (wrap) begin
        vpos       <= '0;
        long_field <= ilace_en ? ~long_field : 1'b0;
      end else if (line_end) begin
        vpos <= vpos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/beam_pos_counter.sv
module beam_pos_counter
  import beam_pkg::*;
#(
  parameter int  H_SHORT_LAST = H_SHORT_LAST_DEF,
  parameter int  NTSC_LINES   = NTSC_LINES_DEF,
  parameter int  PAL_LINES    = PAL_LINES_DEF,
  parameter int  VBEND_LINE   = VBEND_LINE_DEF,
  localparam int HW           = $clog2(H_SHORT_LAST + 2),
  localparam int VW           = $clog2(PAL_LINES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pal_sel,
  input  logic             ilace_en,
  output logic [HW-1:0]    hpos,
  output logic [VW-1:0]    vpos,
  output logic [CMP_W-1:0] vcmp,
  output logic             long_line,
  output logic             long_field,
  output logic             vb_start,
  output logic             vb_end
);
  logic line_end;

  beam_hcnt #(.H_SHORT_LAST(H_SHORT_LAST), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel),
    .hpos(hpos), .long_line(long_line), .line_end(line_end)
  );

  beam_vcnt #(.NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
              .VBEND_LINE(VBEND_LINE), .VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .pal_sel(pal_sel),
    .ilace_en(ilace_en), .vpos(vpos), .long_field(long_field),
    .vb_start(vb_start), .vb_end(vb_end)
  );

  generate
    if (VW >= CMP_W) begin : g_cmp_trunc
      assign vcmp = vpos[CMP_W-1:0];
    end else begin : g_cmp_pad
      assign vcmp = {{(CMP_W - VW){1'b0}}, vpos};
    end
  endgenerate
endmodule

// File: rtl/beam_pos_chk.sv
module beam_pos_chk #(
  parameter int HW           = 8,
  parameter int VW           = 9,
  parameter int H_SHORT_LAST = 226,
  parameter int PAL_LINES    = 312,
  parameter int VBEND_LINE   = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pal_sel,
  input logic [HW-1:0] hpos,
  input logic [VW-1:0] vpos,
  input logic          long_line,
  input logic          long_field,
  input logic          vb_start,
  input logic          vb_end
);
  localparam logic [HW-1:0] LAST_S = HW'(H_SHORT_LAST);
  localparam logic [HW-1:0] LAST_L = HW'(H_SHORT_LAST + 1);

  p_short_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !long_line |-> hpos <= LAST_S);
  p_long_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hpos <= LAST_L);
  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != 0) |-> hpos == $past(hpos) + 1'b1);
  p_pal_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pal_sel) && hpos == 0) |-> !long_line);
  p_vhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != 0) |-> $stable(vpos));
  p_vmax_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vpos <= VW'(PAL_LINES));
  p_field_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != 0 || vpos != 0) |-> $stable(long_field));
  p_vbs_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vb_start |-> (hpos == 0 && vpos == 0));
  p_vbs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vb_start |=> !vb_start);
  p_vbe_place_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vb_end |-> (hpos == 0 && vpos == VW'(VBEND_LINE)));
endmodule

bind beam_pos_counter beam_pos_chk #(
  .HW(HW), .VW(VW), .H_SHORT_LAST(H_SHORT_LAST),
  .PAL_LINES(PAL_LINES), .VBEND_LINE(VBEND_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .hpos(hpos), .vpos(vpos),
  .long_line(long_line), .long_field(long_field),
  .vb_start(vb_start), .vb_end(vb_end)
);

// File: tb/sim_beam_pos_counter.sv
`timescale 1ns/1ps
module sim_beam_pos_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // full-size instance
  logic       rst0_n, pal0, il0;
  logic [7:0] h0, c0;
  logic [8:0] v0;
  logic       ll0, lf0, vs0, ve0;

  // shortened instance: 6/8 line fields, blank end on line 2
  logic       rst1_n, pal1, il1;
  logic [7:0] h1, c1;
  logic [3:0] v1;
  logic       ll1, lf1, vs1, ve1;

  beam_pos_counter u0 (
    .clk(clk), .rst_n(rst0_n), .pal_sel(pal0), .ilace_en(il0),
    .hpos(h0), .vpos(v0), .vcmp(c0), .long_line(ll0), .long_field(lf0),
    .vb_start(vs0), .vb_end(ve0)
  );

  beam_pos_counter #(.NTSC_LINES(6), .PAL_LINES(8), .VBEND_LINE(2)) u1 (
    .clk(clk), .rst_n(rst1_n), .pal_sel(pal1), .ilace_en(il1),
    .hpos(h1), .vpos(v1), .vcmp(c1), .long_line(ll1), .long_field(lf1),
    .vb_start(vs1), .vb_end(ve1)
  );

  logic       use1;
  logic [7:0] obs_h, obs_c;
  logic [8:0] obs_v;
  logic       obs_ll, obs_lf, obs_vs, obs_ve;

  always_comb begin
    obs_h  = use1 ? h1 : h0;
    obs_v  = use1 ? {5'd0, v1} : v0;
    obs_c  = use1 ? c1 : c0;
    obs_ll = use1 ? ll1 : ll0;
    obs_lf = use1 ? lf1 : lf0;
    obs_vs = use1 ? vs1 : vs0;
    obs_ve = use1 ? ve1 : ve0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {small, pal, ilace, reset, last_long, long_field, lines[9:0]}
  localparam logic [15:0] TBL [13] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd262},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd312},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd6},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd7},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd6},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd7},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd6},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd8},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd9},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd6},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd6}
  };

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..R9 run) actual=190000 expected<190000 cycles");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic prev_ll;

  initial begin
    rst0_n = 1'b0; rst1_n = 1'b0;
    pal0 = 1'b0; il0 = 1'b0; pal1 = 1'b0; il1 = 1'b0;
    use1 = 1'b0; prev_ll = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state on both instances
    chk("R1 reset state u0", int'({h0, v0, ll0, lf0, vs0, ve0}), 0);
    chk("R1 reset state u1", int'({h1, v1, ll1, lf1, vs1, ve1}), 0);

    for (int i = 0; i < 13; i++) begin
      logic [15:0] e;
      logic pal, il, ll, last_ll, lf_start, first;
      int lines, bad, vbs_mid, vbe_cnt, vbe_bad, cmp_bad, len, mx, exp_len, vbend, c256;
      e = TBL[i];
      use1 = e[15]; pal = e[14]; il = e[13];
      vbend = e[15] ? 2 : 20;
      if (e[15]) begin pal1 = pal; il1 = il; end
      else       begin pal0 = pal; il0 = il; end
      if (e[12]) begin
        if (e[15]) rst1_n = 1'b0; else rst0_n = 1'b0;
        repeat (2) @(negedge clk);
        if (e[15]) rst1_n = 1'b1; else rst0_n = 1'b1;
        prev_ll = 1'b1;
        #0.5;
        chk("R8 no frame pulse right after reset", int'(obs_vs), 0);
      end
      lines = 0; bad = 0; vbs_mid = 0; vbe_cnt = 0; vbe_bad = 0; cmp_bad = 0;
      c256 = 99; first = 1'b1; last_ll = 1'b0; lf_start = obs_lf;
      do begin
        len = 0; mx = 0; ll = obs_ll;
        do begin
          if (!first && obs_vs) vbs_mid++;
          if (obs_ve) begin
            vbe_cnt++;
            if (obs_v != 9'(vbend) || obs_h != 0) vbe_bad++;
          end
          if (obs_c != obs_v[7:0]) cmp_bad++;
          if (obs_v == 9'd256 && obs_h == 0) c256 = int'(obs_c);
          if (obs_ll != ll) bad++;
          first = 1'b0; len++; mx = int'(obs_h);
          @(negedge clk);
        end while (obs_h != 0);
        exp_len = (!pal && ll) ? 228 : 227;
        if (len != exp_len) bad++;
        if (mx != len - 1) bad++;
        if (ll != (pal ? 1'b0 : ~prev_ll)) bad++;
        prev_ll = ll; last_ll = ll; lines++;
      end while (obs_v != 0);

      if (il) chk("R5 field line count", lines, int'(e[9:0]));
      else    chk("R4 field line count", lines, int'(e[9:0]));
      if (il && !pal) chk("R6 last line type", int'(last_ll), int'(e[11]));
      else            chk("R2 last line type", int'(last_ll), int'(e[11]));
      chk("R5 field flag", int'(lf_start), int'(e[10]));
      if (pal) chk("R3 line lengths and flag", bad, 0);
      else     chk("R2 line lengths and alternation", bad, 0);
      chk("R8 frame pulse at wrap", int'(obs_vs), 1);
      chk("R8 no frame pulse inside field", vbs_mid, 0);
      chk("R9 blank-end pulse count", vbe_cnt, 1);
      chk("R9 blank-end pulse place", vbe_bad, 0);
      chk("R7 compare value low bits", cmp_bad, 0);
      if (!e[15]) chk("R7 line 256 compares as 0", c256, 0);
    end

    // directed: reset in the middle of a field
    use1 = 1'b1;
    repeat (300) @(negedge clk);
    rst1_n = 1'b0;
    #0.5;
    chk("R1 mid-run reset clears outputs", int'({h1, v1, ll1, lf1, vs1, ve1}), 0);
    @(negedge clk);
    rst1_n = 1'b1;
    #0.5;
    chk("R8 no frame pulse after mid-run reset", int'(vs1), 0);
    @(negedge clk);
    chk("R2 count resumes from 0", int'(h1), 1);
    chk("R2 first line after reset is short", int'(ll1), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule